// File: doc/BRIEF.md
# EEPROM Status Register Write-Protect Unit

This unit holds the status byte of a serial EEPROM and decides, in the same cycle, whether each write request is granted or denied. The command decoder feeds it requests to set or clear the write-enable latch, to write the status register with a data byte, and to write the memory array at a 17-bit address. It also samples the active-low write-protect pin and the busy flag of the internal write timer.

Two status bits select a protection level: none, the top quarter, the top half or the whole array. A hardware lock is active when the pin is low and the lock-enable status bit is set. While the lock is active, it refuses every status write, so the lock-enable bit cannot free itself. The nonvolatile bits are modelled as registers that load parameterised power-on values at reset. While the timer is busy, the status byte reads as all ones.

Top module: `eesr_protect_unit`

## Requirements
- R1: When not busy, the status byte is bit 0 = 0, bit 1 = write-enable latch, bit 2 = BP0, bit 3 = BP1, bits 6:4 = 0, bit 7 = lock-enable (WPEN).
- R2: While `busy` is 1, `status_q` is 8'hFF.
- R3: The protected region depends on {BP1,BP0}: 00 covers nothing, 01 covers 0x18000..0x1FFFF, 10 covers 0x10000..0x1FFFF and 11 covers 0x00000..0x1FFFF.
- R4: An array write whose address is inside the protected region is always denied.
- R5: The hardware lock is active when `wp_n` = 0 and WPEN = 1. While it is active, status writes are denied and BP0, BP1 and WPEN hold their values. Array writes outside the region are not affected by the lock.
- R6: While the write-enable latch is 0, all status and array writes are denied.
- R7: When the latch is 1, the lock is inactive and the unit is not busy, a status write is granted. From the next cycle, bits 2, 3 and 7 take the data byte's bits 2, 3 and 7. Data bits 0, 1 and 6:4 have no effect.
- R8: `wel_set_req` sets the latch and `wel_clr_req` clears it from the next cycle. Clear wins when both are raised. A granted status or array write also clears the latch.
- R9: While `busy` is 1, all write requests are denied, and latch set and clear requests are ignored.
- R10: Synchronous reset clears the latch and loads BP from `POR_BP` and WPEN from `POR_WPEN`.
- R11: If a status write and an array write are requested in the same cycle, the status write is judged on its own rules and the array write is denied.
- R12: Each grant or deny output is 1 only in a cycle in which the matching request is 1. In such a cycle, exactly one of the pair is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wel_set_req | input | 1 | Request to set the write-enable latch |
| wel_clr_req | input | 1 | Request to clear the write-enable latch |
| sr_wr_req | input | 1 | Status register write request |
| sr_wr_data | input | 8 | Status write data byte |
| arr_wr_req | input | 1 | Array write request |
| arr_wr_addr | input | ADDR_W (17) | Array write address |
| wp_n | input | 1 | Write-protect pin, active low |
| busy | input | 1 | Internal write cycle in progress |
| status_q | output | 8 | Status byte returned by a status read |
| sr_wr_grant | output | 1 | Status write accepted |
| sr_wr_deny | output | 1 | Status write refused |
| arr_wr_grant | output | 1 | Array write accepted |
| arr_wr_deny | output | 1 | Array write refused |

## Verification
The region decoder is tried with addresses on each side of every level's lower boundary and at the array ends, under all four protection levels. This separates a boundary that is off by one and a level that decodes the wrong bit pair. Status writes carry ones in the bits that cannot be written, so a missing mask shows up. The lock is tried with the pin high and then low while WPEN is set. This shows that status writes and unprotected array writes are gated differently. Busy is applied while the latch is set and while it is clear, and a latch request, a clear/set collision and simultaneous status and array requests are included. This shows that busy, the latch priority and the write ordering are each handled.

// File: rtl/eesr_pkg.sv
package eesr_pkg;

    typedef enum logic [1:0] {
        PROT_NONE    = 2'b00,
        PROT_QUARTER = 2'b01,
        PROT_HALF    = 2'b10,
        PROT_ALL     = 2'b11
    } prot_lvl_e;

    typedef struct packed {
        logic      wpen;
        prot_lvl_e bp;
    } nv_bits_t;

    localparam logic [7:0] STATUS_BUSY = 8'hFF;

    function automatic nv_bits_t nv_from_byte(input logic [7:0] b);
        nv_bits_t n;
        n.wpen = b[7];
        n.bp   = prot_lvl_e'(b[3:2]);
        return n;
    endfunction

    function automatic logic [7:0] status_byte(input logic bsy, input logic wel,
                                               input nv_bits_t n);
        if (bsy) return STATUS_BUSY;
        return {n.wpen, 3'b000, n.bp, wel, 1'b0};
    endfunction

    function automatic logic hw_lock(input logic pin_n, input logic wpen);
        return !pin_n && wpen;
    endfunction

endpackage

// File: rtl/eesr_region_check.sv
module eesr_region_check
    import eesr_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  prot_lvl_e          level,
    input  logic [ADDR_W-1:0]  addr,
    output logic               hit
);
    localparam logic [ADDR_W-1:0] QUARTER_BASE = {2'b11, {(ADDR_W-2){1'b0}}};
    localparam logic [ADDR_W-1:0] HALF_BASE    = {1'b1,  {(ADDR_W-1){1'b0}}};

    always_comb begin
        unique case (level)
            PROT_NONE:    hit = 1'b0;
            PROT_QUARTER: hit = (addr >= QUARTER_BASE);
            PROT_HALF:    hit = (addr >= HALF_BASE);
            default:      hit = 1'b1;
        endcase
    end
endmodule

// File: rtl/eesr_arbiter.sv
module eesr_arbiter (
    input  logic clk,
    input  logic rst,
    input  logic busy,
    input  logic wel,
    input  logic locked,
    input  logic region_hit,
    input  logic sr_req,
    input  logic arr_req,
    output logic sr_grant,
    output logic sr_deny,
    output logic arr_grant,
    output logic arr_deny
);
    logic may_write;

    always_comb begin
        may_write = wel && !busy;
        sr_grant  = sr_req && may_write && !locked;
        arr_grant = arr_req && may_write && !region_hit && !sr_req;
        sr_deny   = sr_req && !sr_grant;
        arr_deny  = arr_req && !arr_grant;
    end

    AST_NO_GRANT_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> !sr_grant && !arr_grant); // R9
    AST_NO_GRANT_NO_WEL: assert property (@(posedge clk) disable iff (rst)
        !wel |-> !sr_grant && !arr_grant); // R6
    AST_REGION_DENY: assert property (@(posedge clk) disable iff (rst)
        (arr_req && region_hit) |-> arr_deny); // R4
    AST_LOCK_DENY: assert property (@(posedge clk) disable iff (rst)
        (sr_req && locked) |-> sr_deny); // R5
    AST_ORDER: assert property (@(posedge clk) disable iff (rst)
        (sr_req && arr_req) |-> !arr_grant); // R11
    AST_PAIR_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sr_grant, sr_deny}) && $onehot0({arr_grant, arr_deny})); // R12
endmodule

// File: rtl/eesr_protect_unit.sv
module eesr_protect_unit
    import eesr_pkg::*;
#(
    parameter int         ADDR_W   = 17,
    parameter logic [1:0] POR_BP   = 2'b00,
    parameter logic       POR_WPEN = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wel_set_req,
    input  logic              wel_clr_req,
    input  logic              sr_wr_req,
    input  logic [7:0]        sr_wr_data,
    input  logic              arr_wr_req,
    input  logic [ADDR_W-1:0] arr_wr_addr,
    input  logic              wp_n,
    input  logic              busy,
    output logic [7:0]        status_q,
    output logic              sr_wr_grant,
    output logic              sr_wr_deny,
    output logic              arr_wr_grant,
    output logic              arr_wr_deny
);
    localparam nv_bits_t NV_POR = '{wpen: POR_WPEN, bp: prot_lvl_e'(POR_BP)};

    nv_bits_t nv_q;
    logic     wel_q;
    logic     locked;
    logic     region_hit;

    assign locked   = hw_lock(wp_n, nv_q.wpen);
    assign status_q = status_byte(busy, wel_q, nv_q);

    eesr_region_check #(.ADDR_W(ADDR_W)) u_region (
        .level (nv_q.bp),
        .addr  (arr_wr_addr),
        .hit   (region_hit)
    );

    eesr_arbiter u_arb (
        .clk        (clk),
        .rst        (rst),
        .busy       (busy),
        .wel        (wel_q),
        .locked     (locked),
        .region_hit (region_hit),
        .sr_req     (sr_wr_req),
        .arr_req    (arr_wr_req),
        .sr_grant   (sr_wr_grant),
        .sr_deny    (sr_wr_deny),
        .arr_grant  (arr_wr_grant),
        .arr_deny   (arr_wr_deny)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            nv_q  <= NV_POR;
            wel_q <= 1'b0;
        end else begin
            if (sr_wr_grant) nv_q <= nv_from_byte(sr_wr_data);
            if (!busy) begin
                if (wel_clr_req || sr_wr_grant || arr_wr_grant) wel_q <= 1'b0;
                else if (wel_set_req)                           wel_q <= 1'b1;
            end
        end
    end

    AST_BUSY_STATUS: assert property (@(posedge clk) disable iff (rst)
        busy |-> status_q == STATUS_BUSY); // R2
    AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (!wp_n && nv_q.wpen) |=> $stable(nv_q)); // R5
    AST_WEL_DROP: assert property (@(posedge clk) disable iff (rst)
        (sr_wr_grant || arr_wr_grant) |=> !wel_q); // R8
    AST_WEL_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(wel_q)); // R9
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !busy |-> status_q[6:4] == 3'b000 && !status_q[0]); // R1
endmodule

// File: tb/eesr_protect_unit_tb.sv
module eesr_protect_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wel_set_req = 0, wel_clr_req = 0, sr_wr_req = 0, arr_wr_req = 0;
    logic [7:0]  sr_wr_data = 0;
    logic [16:0] arr_wr_addr = 0;
    logic        wp_n = 1, busy = 0;
    logic [7:0]  status_q;
    logic        sr_wr_grant, sr_wr_deny, arr_wr_grant, arr_wr_deny;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    eesr_protect_unit #(.ADDR_W(17), .POR_BP(2'b10), .POR_WPEN(1'b0)) u_dut (
        .clk(clk), .rst(rst), .wel_set_req(wel_set_req), .wel_clr_req(wel_clr_req),
        .sr_wr_req(sr_wr_req), .sr_wr_data(sr_wr_data), .arr_wr_req(arr_wr_req),
        .arr_wr_addr(arr_wr_addr), .wp_n(wp_n), .busy(busy), .status_q(status_q),
        .sr_wr_grant(sr_wr_grant), .sr_wr_deny(sr_wr_deny),
        .arr_wr_grant(arr_wr_grant), .arr_wr_deny(arr_wr_deny)
    );

    // {bp[1:0], addr[16:0], expected grant}
    localparam int NV = 8;
    localparam logic [19:0] VEC [NV] = '{
        {2'b00, 17'h1FFFF, 1'b1},
        {2'b01, 17'h17FFF, 1'b1},
        {2'b01, 17'h18000, 1'b0},
        {2'b01, 17'h1FFFF, 1'b0},
        {2'b10, 17'h0FFFF, 1'b1},
        {2'b10, 17'h10000, 1'b0},
        {2'b11, 17'h00000, 1'b0},
        {2'b11, 17'h1FFFF, 1'b0}
    };

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_wel();
        @(negedge clk); wel_set_req = 1;
        @(negedge clk); wel_set_req = 0;
    endtask

    // set latch, then request status write; report grant seen
    task automatic sr_write(input logic [7:0] d, output logic g);
        set_wel();
        sr_wr_req = 1; sr_wr_data = d;
        #2 g = sr_wr_grant;
        @(negedge clk); sr_wr_req = 0;
    endtask

    initial begin : watchdog
        #2000000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic g;
        repeat (3) @(negedge clk);
        rst = 0;
        #2 check(status_q == 8'h08, "R10 reset status", status_q, 8'h08);

        // no latch: all writes refused
        arr_wr_req = 1; arr_wr_addr = 17'h00000; sr_wr_req = 1; sr_wr_data = 8'h00;
        #2 check(arr_wr_deny && !arr_wr_grant, "R6 array deny without latch", arr_wr_grant, 0);
        check(sr_wr_deny && !sr_wr_grant, "R6 status deny without latch", sr_wr_grant, 0);
        @(negedge clk); arr_wr_req = 0; sr_wr_req = 0;
        #2 check(status_q == 8'h08, "R6 status unchanged", status_q, 8'h08);

        set_wel();
        #2 check(status_q == 8'h0A, "R1 R8 latch visible", status_q, 8'h0A);

        // region table walk
        for (int i = 0; i < NV; i++) begin
            logic [7:0] d;
            logic [7:0] expst;
            d = {1'b0, 3'b111, VEC[i][19:18], 2'b11};
            sr_write(d, g);
            expst = {1'b0, 3'b000, VEC[i][19:18], 2'b00};
            #2 check(g && status_q == expst, "R7 masked status write", status_q, expst);
            set_wel();
            arr_wr_req = 1; arr_wr_addr = VEC[i][17:1];
            #2 check(arr_wr_grant == VEC[i][0] && arr_wr_deny == !VEC[i][0],
                     VEC[i][0] ? "R3 region grant" : "R4 region deny", arr_wr_grant, VEC[i][0]);
            @(negedge clk); arr_wr_req = 0;
            #2 check(status_q[1] == !VEC[i][0], "R8 latch after array write", status_q[1], !VEC[i][0]);
        end

        // back to no protection
        sr_write(8'h00, g);
        set_wel();
        busy = 1; arr_wr_req = 1; arr_wr_addr = 0; sr_wr_req = 1; wel_clr_req = 1;
        #2 check(status_q == 8'hFF, "R2 busy status", status_q, 8'hFF);
        check(!arr_wr_grant && !sr_wr_grant && arr_wr_deny && sr_wr_deny,
              "R9 busy deny", {arr_wr_grant, sr_wr_grant}, 0);
        @(negedge clk); arr_wr_req = 0; sr_wr_req = 0; wel_clr_req = 0; busy = 0;
        #2 check(status_q == 8'h02, "R9 clear ignored while busy", status_q, 8'h02);
        @(negedge clk); wel_clr_req = 1;
        @(negedge clk); wel_clr_req = 0;
        #2 check(status_q == 8'h00, "R8 clear request", status_q, 8'h00);
        busy = 1; wel_set_req = 1;
        @(negedge clk); busy = 0; wel_set_req = 0;
        #2 check(status_q == 8'h00, "R9 set ignored while busy", status_q, 8'h00);
        wel_set_req = 1; wel_clr_req = 1;
        @(negedge clk); wel_set_req = 0; wel_clr_req = 0;
        #2 check(status_q == 8'h00, "R8 clear wins", status_q, 8'h00);

        // hardware lock
        sr_write(8'h84, g);
        #2 check(g && status_q == 8'h84, "R7 set WPEN pin high", status_q, 8'h84);
        wp_n = 0;
        sr_write(8'h00, g);
        #2 check(!g && status_q == 8'h86, "R5 locked status write refused", status_q, 8'h86);
        arr_wr_req = 1; arr_wr_addr = 17'h00000;
        #2 check(arr_wr_grant, "R5 unprotected array write under lock", arr_wr_grant, 1);
        @(negedge clk); arr_wr_req = 0;
        wp_n = 1;
        sr_write(8'h00, g);
        #2 check(g && status_q == 8'h00, "R5 pin high releases lock", status_q, 8'h00);

        // simultaneous requests
        set_wel();
        sr_wr_req = 1; sr_wr_data = 8'h00; arr_wr_req = 1; arr_wr_addr = 0;
        #2 check(sr_wr_grant && arr_wr_deny && !arr_wr_grant, "R11 status first",
                 {sr_wr_grant, arr_wr_grant}, 2'b10);
        @(negedge clk); sr_wr_req = 0; arr_wr_req = 0;
        #2 check(!sr_wr_grant && !sr_wr_deny && !arr_wr_grant && !arr_wr_deny,
                 "R12 idle outputs low", {sr_wr_grant, sr_wr_deny, arr_wr_grant, arr_wr_deny}, 0);

        // reset mid-run
        sr_write(8'h8C, g);
        set_wel();
        rst = 1;
        @(negedge clk); rst = 0;
        #2 check(status_q == 8'h08, "R10 reset reload", status_q, 8'h08);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule